// File: doc/BRIEF.md
# Adaptive Lazy-Count Fetch Throttle

This block sits in a processor front end. It decides how many instruction cache lines the fetch unit may request each cycle. It keeps two running counts from single-bit event pulses:

- the in-flight instructions that an upstream predictor has flagged as slow to issue ("lazy");
- all in-flight instructions.

When the lazy count rises above a threshold, the fetch width drops from two lines to one. When the lazy count falls back to the threshold or below, the fetch width returns to two lines.

The threshold is not fixed. A free-running epoch timer fires once every 1024 cycles. On that cycle a tuner compares the lazy count with the total count using integer arithmetic:

- If lazy instructions make up more than a third of the total, the tuner lowers the threshold, so throttling starts sooner.
- If lazy instructions make up under a twentieth of the total, the tuner raises the threshold.
- Otherwise the threshold is left alone.

The threshold moves in steps of five and saturates between 0 and 64.

The output is held in a two-state machine:

- `FS_WIDE` grants two lines. Transition go-narrow (lazy count > threshold) moves to `FS_NARROW`.
- `FS_NARROW` grants one line. Transition go-wide (lazy count ≤ threshold) moves back to `FS_WIDE`.

The tuner's epoch decision is one of three named outcomes: `ADJ_DOWN`, `ADJ_UP` or `ADJ_HOLD`.

Top module: `lazy_fetch_governor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both counts are zero, the threshold is 15, the epoch timer is at zero and `fetch_lines` reads 2.
- R2: Each count rises by one on its increment pulse and falls by one on its decrement pulse. An increment and a decrement in the same cycle cancel and leave the count unchanged.
- R3: A decrement applied to a count of zero is ignored and the count stays zero. An increment at the all-ones maximum is also ignored.
- R4: The threshold can change only on the epoch cycle. That is every 1024th rising edge, and the first one is the 1024th edge after reset is released.
- R5: On the epoch cycle, if 3 × lazy > total, the threshold drops by 5, saturating at 0.
- R6: Otherwise, on the epoch cycle, if 20 × lazy < total, the threshold rises by 5, saturating at 64.
- R7: On the epoch cycle, when neither condition holds (this includes 3 × lazy = total and 20 × lazy = total), the threshold is unchanged.
- R8: `fetch_lines` is registered. After each rising edge it shows 1 if the lazy count held before that edge exceeded the threshold held before that edge, and 2 otherwise. A count change therefore shows up one cycle after the count register changes.
- R9: `fetch_lines` only ever carries the code 2 (two lines, state `FS_WIDE`) or the code 1 (one line, state `FS_NARROW`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lazy_inc | input | 1 | A lazy-predicted instruction entered flight |
| lazy_dec | input | 1 | A lazy-predicted instruction left flight |
| flight_inc | input | 1 | Any instruction entered flight |
| flight_dec | input | 1 | Any instruction left flight |
| fetch_lines | output | 2 | Maximum cache lines to fetch per cycle (2 or 1) |

## Verification
The hardest state to reach from the ports is a threshold pinned at either saturation bound. The threshold is never visible directly, so it can only be probed by moving the lazy count across it.

To pin the threshold at 64, the stimulus holds a tiny lazy fraction for a dozen epochs. To pin it at 0, the stimulus holds a huge lazy fraction for fifteen epochs. In each case it then aligns to the start of a fresh epoch and walks the lazy count across the expected threshold within that epoch.

With the threshold at zero, the same alignment also exposes count underflow and any ordering fault when an increment and a decrement arrive together, because a count of one already flips the fetch width. A bench reference model tracks every cycle. Hand-computed checks cover the first epoch boundary and the equality cases.

// File: rtl/lazy_gov_pkg.sv
package lazy_gov_pkg;

    typedef enum logic {
        FS_WIDE   = 1'b0,
        FS_NARROW = 1'b1
    } fetch_state_e;

    typedef enum logic [1:0] {
        ADJ_HOLD = 2'd0,
        ADJ_DOWN = 2'd1,
        ADJ_UP   = 2'd2
    } adj_e;

endpackage

// File: rtl/flight_counter.sv
module flight_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] count_nx;

    always_comb begin
        unique case ({inc, dec})
            2'b10:   count_nx = (count == TOP) ? count : count + W'(1);
            2'b01:   count_nx = (count == '0) ? count : count - W'(1);
            default: count_nx = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_nx;
    end

    // R3: a decrement at zero leaves the count at zero
    a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && dec && !inc) |=> count == '0);

    // R2: a simultaneous increment and decrement cancel
    a_r2_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(count));

    // R2: a lone increment below the top adds exactly one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && count != TOP) |=> count == $past(count) + W'(1));

endmodule

// File: rtl/epoch_timer.sv
module epoch_timer #(
    parameter int EPOCH_LEN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = (EPOCH_LEN > 1) ? $clog2(EPOCH_LEN) : 1;
    localparam logic [TW-1:0] LAST = TW'(EPOCH_LEN - 1);

    logic [TW-1:0] phase;

    assign tick = (phase == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= '0;
        else if (tick) phase <= '0;
        else           phase <= phase + TW'(1);
    end

    // R4: the timer restarts right after each epoch tick
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> phase == '0);

    // R4: between ticks the timer advances by one each cycle
    a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> phase == $past(phase) + TW'(1));

endmodule

// File: rtl/threshold_tuner.sv
module threshold_tuner
    import lazy_gov_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int THR_W    = 7,
    parameter int THR_INIT = 15,
    parameter int THR_STEP = 5,
    parameter int THR_MAX  = 64,
    parameter int HI_DEN   = 3,
    parameter int LO_DEN   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] lazy_cnt,
    input  logic [CNT_W-1:0] total_cnt,
    output logic [THR_W-1:0] thr
);
    localparam int PROD_W = CNT_W + $clog2(LO_DEN + 1) + 1;
    localparam logic [THR_W-1:0] STEP_V = THR_W'(THR_STEP);
    localparam logic [THR_W-1:0] MAX_V  = THR_W'(THR_MAX);
    localparam logic [THR_W-1:0] INIT_V = THR_W'(THR_INIT);

    logic [PROD_W-1:0] hi_prod, lo_prod, total_x;
    adj_e              decision;
    logic [THR_W-1:0]  thr_nx;

    assign hi_prod = PROD_W'(lazy_cnt) * PROD_W'(HI_DEN);
    assign lo_prod = PROD_W'(lazy_cnt) * PROD_W'(LO_DEN);
    assign total_x = PROD_W'(total_cnt);

    always_comb begin
        if (hi_prod > total_x)      decision = ADJ_DOWN;
        else if (lo_prod < total_x) decision = ADJ_UP;
        else                        decision = ADJ_HOLD;
    end

    always_comb begin
        unique case (decision)
            ADJ_DOWN: thr_nx = (thr < STEP_V) ? '0 : thr - STEP_V;
            ADJ_UP:   thr_nx = (thr > MAX_V - STEP_V) ? MAX_V : thr + STEP_V;
            default:  thr_nx = thr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    thr <= INIT_V;
        else if (tick) thr <= thr_nx;
    end

    // R4: outside the epoch cycle the threshold holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(thr));

    // R5: a high lazy share near the floor pins the threshold at zero
    a_r5_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hi_prod > total_x && thr < STEP_V) |=> thr == '0);

    // R6: a low lazy share near the ceiling pins the threshold at the maximum
    a_r6_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lo_prod < total_x && hi_prod <= total_x && thr > MAX_V - STEP_V)
        |=> thr == MAX_V);

    // R7: equality on both bounds leaves the threshold alone
    a_r7_equal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hi_prod == total_x && lo_prod >= total_x) |=> $stable(thr));

endmodule

// File: rtl/lazy_fetch_governor.sv
module lazy_fetch_governor
    import lazy_gov_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int EPOCH_LEN    = 1024,
    parameter int THR_INIT     = 15,
    parameter int THR_STEP     = 5,
    parameter int THR_MAX      = 64,
    parameter int LINES_W      = 2,
    parameter int WIDE_LINES   = 2,
    parameter int NARROW_LINES = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lazy_inc,
    input  logic               lazy_dec,
    input  logic               flight_inc,
    input  logic               flight_dec,
    output logic [LINES_W-1:0] fetch_lines
);
    localparam int THR_W = $clog2(THR_MAX + 1);
    localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;
    localparam logic [LINES_W-1:0] WIDE_V   = LINES_W'(WIDE_LINES);
    localparam logic [LINES_W-1:0] NARROW_V = LINES_W'(NARROW_LINES);

    logic [CNT_W-1:0] lazy_cnt, total_cnt;
    logic [THR_W-1:0] thr;
    logic             epoch_tick;
    logic             over_thr;
    fetch_state_e     state, state_nx;

    flight_counter #(.W(CNT_W)) u_lazy_cnt (
        .clk(clk), .rst_n(rst_n), .inc(lazy_inc), .dec(lazy_dec), .count(lazy_cnt)
    );

    flight_counter #(.W(CNT_W)) u_total_cnt (
        .clk(clk), .rst_n(rst_n), .inc(flight_inc), .dec(flight_dec), .count(total_cnt)
    );

    epoch_timer #(.EPOCH_LEN(EPOCH_LEN)) u_epoch (
        .clk(clk), .rst_n(rst_n), .tick(epoch_tick)
    );

    threshold_tuner #(
        .CNT_W(CNT_W), .THR_W(THR_W), .THR_INIT(THR_INIT),
        .THR_STEP(THR_STEP), .THR_MAX(THR_MAX), .HI_DEN(3), .LO_DEN(20)
    ) u_tuner (
        .clk(clk), .rst_n(rst_n), .tick(epoch_tick),
        .lazy_cnt(lazy_cnt), .total_cnt(total_cnt), .thr(thr)
    );

    assign over_thr = CMP_W'(lazy_cnt) > CMP_W'(thr);

    always_comb begin
        unique case (state)
            FS_WIDE:   state_nx = over_thr ? FS_NARROW : FS_WIDE;
            FS_NARROW: state_nx = over_thr ? FS_NARROW : FS_WIDE;
            default:   state_nx = FS_WIDE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FS_WIDE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            FS_NARROW: fetch_lines = NARROW_V;
            default:   fetch_lines = WIDE_V;
        endcase
    end

    // R8: a lazy count above the threshold narrows fetch on the next cycle
    a_r8_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (CMP_W'(lazy_cnt) > CMP_W'(thr)) |=> fetch_lines == NARROW_V);

    // R8: a lazy count at or below the threshold restores full width
    a_r8_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (CMP_W'(lazy_cnt) <= CMP_W'(thr)) |=> fetch_lines == WIDE_V);

    // R9: only the two legal width codes appear
    a_r9_code: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_lines == WIDE_V || fetch_lines == NARROW_V);

endmodule

// File: tb/lazy_fetch_governor_tb.sv
module lazy_fetch_governor_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lazy_inc = 1'b0, lazy_dec = 1'b0;
    logic       flight_inc = 1'b0, flight_dec = 1'b0;
    logic [1:0] fetch_lines;

    int tests = 0;
    int fails = 0;
    int edge_n = 0;

    int m_lazy, m_all, m_thr, m_tmr, m_lines;

    always #5 clk = ~clk;

    lazy_fetch_governor u_dut (
        .clk(clk), .rst_n(rst_n),
        .lazy_inc(lazy_inc), .lazy_dec(lazy_dec),
        .flight_inc(flight_inc), .flight_dec(flight_dec),
        .fetch_lines(fetch_lines)
    );

    // Reference model written from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lazy <= 0; m_all <= 0; m_thr <= 15; m_tmr <= 0; m_lines <= 2;
            edge_n <= 0;
        end else begin
            edge_n  <= edge_n + 1;
            m_lines <= (m_lazy > m_thr) ? 1 : 2;
            if (m_tmr == 1023) begin
                m_tmr <= 0;
                if (3 * m_lazy > m_all)       m_thr <= (m_thr < 5) ? 0 : m_thr - 5;
                else if (20 * m_lazy < m_all) m_thr <= (m_thr > 59) ? 64 : m_thr + 5;
            end else begin
                m_tmr <= m_tmr + 1;
            end
            if (lazy_inc && !lazy_dec && m_lazy < 255) m_lazy <= m_lazy + 1;
            else if (lazy_dec && !lazy_inc && m_lazy > 0) m_lazy <= m_lazy - 1;
            if (flight_inc && !flight_dec && m_all < 255) m_all <= m_all + 1;
            else if (flight_dec && !flight_inc && m_all > 0) m_all <= m_all - 1;
        end
    end

    task automatic check(input int act, input int exp, input string req);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: fetch_lines=%0d expected=%0d at t=%0t", req, act, exp, $time);
        end
    endtask

    // One cycle: compare with the model, then drive events {li, ld, fi, fd}
    task automatic step(input logic [3:0] ev);
        @(negedge clk);
        check(int'(fetch_lines), m_lines, "R8 R5 R6 R7 model");
        {lazy_inc, lazy_dec, flight_inc, flight_dec} = ev;
    endtask

    task automatic settle();
        step(4'b0000);
        step(4'b0000);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {lazy_inc, lazy_dec, flight_inc, flight_dec} = 4'b0000;
        repeat (3) step(4'b0000);
        check(int'(fetch_lines), 2, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic align_epoch();
        step(4'b0000);
        while (m_tmr != 0) step(4'b0000);
    endtask

    localparam int NV = 22;
    localparam logic [15:0] VEC [NV] = '{
        {4'b1010, 12'd5},    {4'b0010, 12'd10},   {4'b0000, 12'd1100},
        {4'b1000, 12'd11},   {4'b0100, 12'd1},    {4'b0100, 12'd10},
        {4'b0011, 12'd20},   {4'b0010, 12'd5},    {4'b0100, 12'd4},
        {4'b0000, 12'd1024}, {4'b1000, 12'd15},   {4'b0100, 12'd1},
        {4'b0100, 12'd14},   {4'b1000, 12'd7},    {4'b0000, 12'd1024},
        {4'b1000, 12'd3},    {4'b0100, 12'd1},    {4'b0001, 12'd3},
        {4'b0100, 12'd10},   {4'b0000, 12'd2100}, {4'b1000, 12'd25},
        {4'b0101, 12'd30}
    };

    initial begin
        #(200000 * 10);
        fails++;
        tests++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        check(int'(fetch_lines), 2, "R1 after release");

        // R4: first epoch edge is the 1024th; lazy 12, total 12 -> threshold 10
        repeat (12) step(4'b1010);
        while (edge_n < 1024) step(4'b0000);
        check(int'(fetch_lines), 2, "R4 before effect");
        step(4'b0000);
        check(int'(fetch_lines), 1, "R4 R5 after drop");

        // R7: lazy 5 of total 15 is exactly one third -> threshold stays 15
        do_reset();
        repeat (5) step(4'b1010);
        repeat (10) step(4'b0010);
        while (edge_n < 1030) step(4'b0000);
        repeat (11) step(4'b1000);
        settle();
        check(int'(fetch_lines), 1, "R7 lazy 16 over 15");
        step(4'b0100);
        settle();
        check(int'(fetch_lines), 2, "R7 lazy 15 at 15");

        // Table of event patterns, checked against the model every cycle
        do_reset();
        for (int i = 0; i < NV; i++) begin
            repeat (int'(VEC[i][11:0])) step(VEC[i][15:12]);
        end

        // R6: ceiling at 64 (lazy 0, total 1 for twelve epochs)
        do_reset();
        step(4'b0010);
        repeat (12 * 1024) step(4'b0000);
        align_epoch();
        repeat (64) step(4'b1000);
        settle();
        check(int'(fetch_lines), 2, "R6 lazy 64 at ceiling");
        step(4'b1000);
        settle();
        check(int'(fetch_lines), 1, "R6 R8 lazy 65 over ceiling");

        // R5: floor at 0 (lazy 65, total 1 for fifteen epochs)
        repeat (15 * 1024) step(4'b0000);
        align_epoch();
        repeat (64) step(4'b0100);
        settle();
        check(int'(fetch_lines), 1, "R5 lazy 1 over floor");
        step(4'b0100);
        settle();
        check(int'(fetch_lines), 2, "R5 lazy 0 at floor");

        // R3: decrements at zero are ignored
        repeat (3) step(4'b0100);
        settle();
        check(int'(fetch_lines), 2, "R3 no underflow");

        // R2: simultaneous inc and dec at zero cancel
        step(4'b1100);
        settle();
        check(int'(fetch_lines), 2, "R2 cancel");
        step(4'b1000);
        settle();
        check(int'(fetch_lines), 1, "R2 R3 single increment from zero");
        step(4'b0100);
        settle();
        check(int'(fetch_lines), 2, "R9 back to wide code");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule